// File: doc/BRIEF.md
# Receiver Polling Mode Sequencer

This block duty-cycles a radio receiver so that it draws full current only when a transmitter is actually present. It loops through a sleep phase, a start-up phase and a bit-check phase. It leaves that loop for a continuous receiving phase only once the demodulated data line has shown a run of edges with plausible half-bit spacing. Every timer advances on an input tick, so the sequencer can run from a slow base clock while the logic itself stays on the system clock.

The sleep length is a programmable 5-bit word, multiplied by a power-of-two extension factor and by a fixed unit of ticks. The start-up length and the accepted half-bit window both scale with a 2-bit baud-range select. If the check fails, the sequencer goes straight back to sleep. Receiving is left only through a synchronous OFF strobe. That strobe also aborts every other phase.

Top module: `rx_poll_seq`

## Requirements
- R1: While rst_n is low and after its release, phase reads 0 (sleep), and proc_en, data_valid and data_out are 0.
- R2: Sleep lasts exactly sleep_word × 2^sleep_ext × UNIT ticks. On the edge that counts the last tick, phase becomes 1 (start-up).
- R3: A sleep_word of 0 gives a sleep length of exactly one tick.
- R4: Start-up lasts exactly SU_BASE × 2^baud_sel ticks, and then phase becomes 2 (bit-check).
- R5: Phases advance only in the order sleep(0) → start-up(1) → bit-check(2) → receiving(3), apart from returns to sleep. proc_en is 1 in every phase except sleep.
- R6: Let the half-bit length be H = HB_BASE × 2^baud_sel, with the accepted interval range H − H/4 to H + H/4 ticks inclusive. Bit-check passes to receiving on the edge that completes 2N such intervals after a first edge. N is 3, 6 or 9 for nbits_sel 0, 1 and 2, and 9 for nbits_sel 3. An edge is a tick on which dem_in differs from its value at the previous tick.
- R7: In bit-check, an interval shorter than H − H/4 ticks returns the sequencer to sleep on that edge. If H + H/4 ticks pass with no edge, the next tick returns it to sleep.
- R8: In receiving, the phase holds for as long as off_cmd is low. data_valid is 1, and data_out equals dem_in.
- R9: An off_cmd high at a clock edge forces phase 0 after that edge, whatever the phase and the tick, and restarts the sleep count.
- R10: A clock edge with tick low and off_cmd low changes neither the phase nor any timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base timing tick, one clock wide |
| sleep_word | input | 5 | Sleep length word |
| sleep_ext | input | 2 | Sleep extension, factor 2^sleep_ext |
| baud_sel | input | 2 | Baud-range select |
| nbits_sel | input | 2 | Bits to check: 3, 6, 9, 9 |
| dem_in | input | 1 | Demodulated data line |
| off_cmd | input | 1 | OFF command strobe |
| proc_en | output | 1 | Signal-processing enable |
| phase | output | 2 | 0 sleep, 1 start-up, 2 bit-check, 3 receiving |
| data_out | output | 1 | Data pass-through, 0 outside receiving |
| data_valid | output | 1 | High in receiving |

## Verification
The bench builds the block with UNIT = 4, SU_BASE = 3 and HB_BASE = 4. These values shrink the timers far enough that every sleep word under every extension factor, every baud range and every bit count can be swept in full. The half-bit windows then span 3–5 up to 24–40 ticks. The interval bounds are probed exactly at the minimum and the maximum, and one tick outside each. An OFF strobe is also injected into each phase.

// File: rtl/rx_poll_seq.sv
module rx_poll_seq #(
  parameter int UNIT    = 1024,
  parameter int SU_BASE = 64,
  parameter int HB_BASE = 8,
  parameter int CW      = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [4:0] sleep_word,
  input  logic [1:0] sleep_ext,
  input  logic [1:0] baud_sel,
  input  logic [1:0] nbits_sel,
  input  logic       dem_in,
  input  logic       off_cmd,
  output logic       proc_en,
  output logic [1:0] phase,
  output logic       data_out,
  output logic       data_valid
);
  typedef enum logic [1:0] {PH_SLEEP, PH_START, PH_CHECK, PH_RECV} ph_t;

  ph_t           ph;
  logic [CW-1:0] cnt, iv, sleep_len, start_len, hb, lo, hi;
  logic [4:0]    ecnt, need;
  logic          prev, edge_seen, bad;

  assign sleep_len = (sleep_word == 5'd0) ? CW'(1)
                   : (CW'(sleep_word) * CW'(UNIT)) << sleep_ext;
  assign start_len = CW'(SU_BASE) << baud_sel;
  assign hb        = CW'(HB_BASE) << baud_sel;
  assign lo        = hb - (hb >> 2);
  assign hi        = hb + (hb >> 2);
  assign iv        = cnt + CW'(1);
  assign edge_seen = dem_in ^ prev;
  assign bad       = (iv > hi) || (edge_seen && ecnt != 5'd0 && iv < lo);

  always_comb begin
    case (nbits_sel)
      2'd0:    need = 5'd7;
      2'd1:    need = 5'd13;
      default: need = 5'd19;
    endcase
  end

  assign phase      = ph;
  assign proc_en    = (ph != PH_SLEEP);
  assign data_valid = (ph == PH_RECV);
  assign data_out   = dem_in & data_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)    prev <= 1'b0;
    else if (tick) prev <= dem_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || off_cmd) begin
      ph   <= PH_SLEEP;
      cnt  <= '0;
      ecnt <= '0;
    end else if (tick) begin
      case (ph)
        PH_SLEEP:
          if (iv >= sleep_len) begin ph <= PH_START; cnt <= '0; end
          else cnt <= iv;
        PH_START:
          if (iv >= start_len) begin ph <= PH_CHECK; cnt <= '0; ecnt <= '0; end
          else cnt <= iv;
        PH_CHECK:
          if (bad) begin
            ph <= PH_SLEEP; cnt <= '0; ecnt <= '0;
          end else if (edge_seen) begin
            cnt  <= '0;
            ecnt <= ecnt + 5'd1;
            if (ecnt + 5'd1 == need) ph <= PH_RECV;
          end else cnt <= iv;
        default: ;
      endcase
    end
  end

  AST_OFF_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    off_cmd |=> ph == PH_SLEEP); // R9
  AST_RECV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RECV && !off_cmd) |=> ph == PH_RECV); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !off_cmd) |=> ($stable(ph) && $stable(cnt))); // R10
  AST_SLEEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SLEEP && !off_cmd) |=> (ph == PH_SLEEP || ph == PH_START)); // R5
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_START && !off_cmd) |=> (ph == PH_START || ph == PH_CHECK)); // R5
  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SLEEP && tick && !off_cmd && sleep_word == 5'd0) |=> ph == PH_START); // R3
endmodule

// File: tb/test_rx_poll_seq.sv
module test_rx_poll_seq;
  logic clk = 0, rst_n = 0, tick = 0, dem = 0, off_cmd = 0;
  logic [4:0] sleep_word = 0;
  logic [1:0] sleep_ext = 0, baud_sel = 0, nbits_sel = 0;
  logic proc_en, data_out, data_valid;
  logic [1:0] phase;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rx_poll_seq #(.UNIT(4), .SU_BASE(3), .HB_BASE(4), .CW(24)) i_rx_poll_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_word(sleep_word),
    .sleep_ext(sleep_ext), .baud_sel(baud_sel), .nbits_sel(nbits_sel),
    .dem_in(dem), .off_cmd(off_cmd), .proc_en(proc_en), .phase(phase),
    .data_out(data_out), .data_valid(data_valid));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit t);
    @(negedge clk); tick = t;
    @(posedge clk); #1;
  endtask

  task automatic pulse_off();
    @(negedge clk); off_cmd = 1; tick = 0;
    @(posedge clk); #1; off_cmd = 0;
  endtask

  task automatic leave(input logic [1:0] from, output int n);
    n = 0;
    while (phase == from && n < 5000) begin step(1); n++; end
  endtask

  task automatic goto_check(input int b);
    int n;
    pulse_off(); sleep_word = 0; baud_sel = 2'(b);
    leave(2'd0, n); leave(2'd1, n);
  endtask

  initial begin
    int n, hb, lo, hi, nb;
    repeat (3) step(0);
    dem = 1; #1;
    chk(phase == 0 && !proc_en && !data_valid && !data_out, "R1 reset", phase, 0);
    @(negedge clk); rst_n = 1;
    step(0);
    chk(phase == 0 && !proc_en && !data_valid, "R1 after release", phase, 0);
    dem = 0;

    for (int x = 0; x < 4; x++)
      for (int w = 0; w < 32; w++) begin
        pulse_off(); sleep_word = 5'(w); sleep_ext = 2'(x);
        leave(2'd0, n);
        if (w == 0) chk(n == 1 && phase == 1, "R3 zero word", n, 1);
        else        chk(n == w * (1 << x) * 4 && phase == 1, "R2 sleep length", n, w * (1 << x) * 4);
      end
    sleep_ext = 0;

    for (int b = 0; b < 4; b++) begin
      pulse_off(); sleep_word = 0; baud_sel = 2'(b);
      leave(2'd0, n);
      chk(proc_en == 1, "R5 enable in start-up", proc_en, 1);
      leave(2'd1, n);
      chk(n == 3 * (1 << b) && phase == 2, "R4 start-up length", n, 3 * (1 << b));
    end

    pulse_off(); sleep_word = 1;
    for (int i = 0; i < 4; i++) begin
      step(1); step(0);
      if (i < 3) chk(phase == 0, "R10 idle clock holds", phase, 0);
    end
    chk(phase == 1, "R10 only ticks count", phase, 1);
    for (int i = 0; i < 5; i++) step(0);
    chk(phase == 1, "R10 start-up holds", phase, 1);

    pulse_off(); sleep_word = 2;
    for (int i = 0; i < 5; i++) step(1);
    pulse_off();
    chk(phase == 0, "R9 off in sleep", phase, 0);
    leave(2'd0, n);
    chk(n == 8, "R9 sleep count restarts", n, 8);
    pulse_off();
    chk(phase == 0, "R9 off in start-up", phase, 0);

    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 4; s++)
        for (int m = 0; m < 2; m++) begin
          hb = 4 << b; lo = hb - hb / 4; hi = hb + hb / 4;
          nb = (s == 0) ? 3 : (s == 1) ? 6 : 9;
          nbits_sel = 2'(s);
          goto_check(b);
          dem = ~dem; step(1);
          for (int i = 1; i <= 2 * nb; i++) begin
            for (int k = 1; k < ((m == 0) ? lo : hi); k++) step(1);
            if (i == 2 * nb) chk(phase == 2, "R6 still checking", phase, 2);
            dem = ~dem; step(1);
          end
          chk(phase == 3 && data_valid, "R6 pass to receiving", phase, 3);
        end

    for (int i = 0; i < 40; i++) begin
      dem = (i % 3 == 0); step(i % 2);
      chk(phase == 3 && data_valid && proc_en && data_out == dem, "R8 receiving pass-through", data_out, dem);
    end
    pulse_off();
    chk(phase == 0 && !data_valid && !data_out, "R9 off in receiving", phase, 0);

    for (int b = 0; b < 4; b++) begin
      hb = 4 << b; lo = hb - hb / 4; hi = hb + hb / 4;
      goto_check(b);
      dem = ~dem; step(1);
      for (int k = 1; k < lo - 1; k++) step(1);
      chk(phase == 2, "R7 before short edge", phase, 2);
      dem = ~dem; step(1);
      chk(phase == 0, "R7 short interval", phase, 0);
      goto_check(b);
      dem = ~dem; step(1);
      for (int k = 0; k < hi; k++) step(1);
      chk(phase == 2, "R7 at max interval", phase, 2);
      step(1);
      chk(phase == 0, "R7 long interval", phase, 0);
    end

    goto_check(0);
    pulse_off();
    chk(phase == 0 && !proc_en, "R9 off in bit-check", phase, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule